// File: doc/BRIEF.md
# Four-Channel Compare System Timer

This block is a memory-mapped system timer: a 64-bit free-running count advanced by one on every clock cycle in which the tick-enable input is high, plus four 32-bit compare channels. The tick-enable input is normally a one-microsecond strobe from a prescaler outside the block. A channel fires when a tick makes the low 32 bits of the count equal to its compare value. When it fires, it sets its status bit and raises its own level interrupt line. Software clears both by writing a one to that bit's position in the status register.

Software reaches the timer over a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. Writes take effect at the clock edge where the strobe is high. The word map is: status at 0x00, count low at 0x04, count high at 0x08, and channel n's compare value at 0x0C + 4·n, up to 0x18, inside a 0x20-byte window.

Top module: `sys_compare_timer`

## Requirements
- R1: The count is 64 bits wide. It increases by exactly one at every clock edge where `tick_en` is high, and it holds its value when `tick_en` is low. A wrap of the low word carries into the high word.
- R2: Reads at 0x04 return count bits 31:0 and reads at 0x08 return count bits 63:32. Both registers are read-only, and a write to either leaves the count unchanged.
- R3: Channel n's compare value sits at 0x0C + 4·n for n = 0..3. A read there returns the last value written, or zero after reset.
- R4: Channel n fires only on a tick that makes count bits 31:0 equal to its compare value; bits 63:32 take no part. Writing a compare value equal to the current low word does not fire the channel. Neither do cycles without a tick.
- R5: When channel n fires, bit n of the status register (0x00, bits 3:0, upper bits read zero) is set and `irq[n]` goes high. Both stay high until software clears them.
- R6: A write to 0x00 clears each status bit, and drops the matching `irq` line, wherever the written data has a one. Bits written as zero keep their value.
- R7: If a channel fires in the same cycle as a clear write to its bit, the bit ends up set.
- R8: Reads at offset 0x1C, and at any address whose two low bits are not zero, return zero. Writes there change nothing.
- R9: Reset loads the count with the `RESET_COUNT` parameter (zero by default) and clears all compare values, all status bits and all `irq` lines.
- R10: Several channels that match on the same tick each set their own bit and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the count at this edge |
| bus_addr | input | 5 | Byte address inside the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 4 | Per-channel level interrupt |

## Verification
The bench keeps four channels and a 64-bit count, but sets `RESET_COUNT` to 0x0000_0000_FFFF_FFF0. This puts the low-word wrap within sixteen ticks. It can then watch the carry into the high word, and a match on a small compare value while the high word is nonzero. The compare values are placed so that one channel fires before the wrap and one after it. Two more channels fire together on a single tick, and one match lands in the same cycle as a clear of its own bit.

// File: rtl/st_timer_pkg.sv
package st_timer_pkg;

    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 5;
    localparam int IDX_W        = ADDR_W - 2;
    localparam int CTRL_IDX     = 0;
    localparam int CNT_LO_IDX   = 1;
    localparam int CNT_HI_IDX   = 2;
    localparam int CMP_BASE_IDX = 3;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } reg_dec_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] addr,
                                             input int num_ch);
        reg_dec_t d;
        d.idx = addr[ADDR_W-1:2];
        d.hit = (addr[1:0] == 2'b00) &&
                ({1'b0, d.idx} < (IDX_W+1)'(CMP_BASE_IDX + num_ch));
        return d;
    endfunction

endpackage

// File: rtl/st_counter.sv
module st_counter #(
    parameter int              CNT_W       = 64,
    parameter logic [CNT_W-1:0] RESET_COUNT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);

    assign cnt_next = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RESET_COUNT;
        else if (tick_en)
            cnt_q <= cnt_next;
    end

endmodule

// File: rtl/st_compare_chan.sv
module st_compare_chan #(
    parameter int CMP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [CMP_W-1:0] lo_next,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic             clr,
    output logic [CMP_W-1:0] cmp_q,
    output logic             flag_q
);

    logic hit;

    // match on the tick that brings the low word onto the compare value
    assign hit = tick_en && (lo_next == cmp_q);

    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '0;
        else if (cmp_we)
            cmp_q <= cmp_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;     // set has priority over a coincident clear
        else if (clr)
            flag_q <= 1'b0;
    end

endmodule

// File: rtl/st_wr_decode.sv
module st_wr_decode
    import st_timer_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  bus_req_t          req,
    output logic [NUM_CH-1:0] cmp_we,
    output logic [NUM_CH-1:0] clr_mask
);

    reg_dec_t dec;

    assign dec = decode_addr(req.addr, NUM_CH);

    assign clr_mask = (req.wr && dec.hit && dec.idx == IDX_W'(CTRL_IDX))
                      ? req.data[NUM_CH-1:0] : '0;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_we
        assign cmp_we[n] = req.wr && dec.hit && (dec.idx == IDX_W'(CMP_BASE_IDX + n));
    end

endmodule

// File: rtl/st_rd_mux.sv
module st_rd_mux
    import st_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 64
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0]             status,
    input  logic [CNT_W-1:0]              cnt,
    input  logic [NUM_CH-1:0][DATA_W-1:0] cmp,
    output logic [DATA_W-1:0]             rdata
);

    reg_dec_t dec;

    assign dec = decode_addr(addr, NUM_CH);

    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            if (dec.idx == IDX_W'(CTRL_IDX))
                rdata = {{(DATA_W-NUM_CH){1'b0}}, status};
            else if (dec.idx == IDX_W'(CNT_LO_IDX))
                rdata = cnt[DATA_W-1:0];
            else if (dec.idx == IDX_W'(CNT_HI_IDX))
                rdata = cnt[CNT_W-1:DATA_W];
            for (int n = 0; n < NUM_CH; n++) begin
                if (dec.idx == IDX_W'(CMP_BASE_IDX + n))
                    rdata = cmp[n];
            end
        end
    end

endmodule

// File: rtl/sys_compare_timer.sv
module sys_compare_timer
    import st_timer_pkg::*;
#(
    parameter int               NUM_CH      = 4,
    parameter int               CNT_W       = 64,
    parameter logic [CNT_W-1:0] RESET_COUNT = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int LO_W = DATA_W;

    bus_req_t                  req;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          cnt_next;
    logic [NUM_CH-1:0]         cmp_we;
    logic [NUM_CH-1:0]         clr_mask;
    logic [NUM_CH-1:0][LO_W-1:0] cmp_val;
    logic [NUM_CH-1:0]         status;

    assign req = '{wr: bus_we, addr: bus_addr, data: bus_wdata};

    st_counter #(.CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt_q   (cnt_q),
        .cnt_next(cnt_next)
    );

    st_wr_decode #(.NUM_CH(NUM_CH)) u_wr (
        .req     (req),
        .cmp_we  (cmp_we),
        .clr_mask(clr_mask)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        st_compare_chan #(.CMP_W(LO_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick_en  (tick_en),
            .lo_next  (cnt_next[LO_W-1:0]),
            .cmp_we   (cmp_we[n]),
            .cmp_wdata(bus_wdata),
            .clr      (clr_mask[n]),
            .cmp_q    (cmp_val[n]),
            .flag_q   (status[n])
        );
    end

    st_rd_mux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_rd (
        .addr  (bus_addr),
        .status(status),
        .cnt   (cnt_q),
        .cmp   (cmp_val),
        .rdata (bus_rdata)
    );

    assign irq = status;

endmodule

// File: rtl/st_timer_checker.sv
module st_timer_checker
    import st_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] irq,
    input logic [CNT_W-1:0]  cnt
);

    logic [NUM_CH-1:0] clr_w;
    assign clr_w = (bus_we && bus_addr == '0) ? bus_wdata[NUM_CH-1:0] : '0;

    // R1
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> cnt == $past(cnt) + CNT_W'(1));
    // R1
    a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(cnt));
    // R4
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        (|(irq & ~$past(irq))) |-> $past(tick_en));
    // R5
    a_r5_irq_held: assert property (@(posedge clk) disable iff (rst)
        (|irq) |=> ((irq & $past(irq & ~clr_w)) == $past(irq & ~clr_w)));
    // R6
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == '0 && !tick_en) |=>
            ((irq & $past(bus_wdata[NUM_CH-1:0])) == '0));
    // R8
    a_r8_unaligned_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

endmodule

bind sys_compare_timer st_timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .cnt      (cnt_q)
);

// File: tb/tb_sys_compare_timer.sv
module tb_sys_compare_timer;

    localparam logic [63:0] INIT = 64'h0000_0000_FFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    always #2.5 clk = ~clk;

    sys_compare_timer #(.NUM_CH(4), .CNT_W(64), .RESET_COUNT(INIT)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        bit          is_irq;
        logic [4:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            @(negedge clk);
            it = q.pop_front();
            if (!it.is_irq) bus_addr = it.addr;
            #1;
            total++;
            if (it.is_irq) begin
                if ({28'b0, irq} !== it.exp) begin
                    bad++;
                    $display("FAIL %s irq actual=%h expected=%h", it.tag, irq, it.exp);
                end
            end else if (bus_rdata !== it.exp) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
            end
        end
    end

    task automatic chk(input bit is_irq, input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = is_irq; it.addr = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        #2;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(0, 5'h00, 32'h0, "R9 status");
        chk(1, 5'h00, 32'h0, "R9 irq");
        chk(0, 5'h04, 32'hFFFF_FFF0, "R9 count low");
        chk(0, 5'h08, 32'h0, "R9 count high");
        for (int n = 0; n < 4; n++) chk(0, 5'(12 + 4*n), 32'h0, "R9 compare");
        // R3 compare readback
        wr(5'h0C, 32'hFFFF_FFF5);
        wr(5'h10, 32'h0000_0003);
        wr(5'h14, 32'h0000_0010);
        wr(5'h18, 32'h0000_0040);
        chk(0, 5'h0C, 32'hFFFF_FFF5, "R3 cmp0");
        chk(0, 5'h10, 32'h0000_0003, "R3 cmp1");
        chk(0, 5'h14, 32'h0000_0010, "R3 cmp2");
        chk(0, 5'h18, 32'h0000_0040, "R3 cmp3");
        // R1 / R4 ticks up to just before match
        ticks(4);
        chk(0, 5'h04, 32'hFFFF_FFF4, "R1 count after 4");
        chk(1, 5'h00, 32'h0, "R4 no early fire");
        ticks(1);
        chk(0, 5'h00, 32'h1, "R5 status ch0");
        chk(1, 5'h00, 32'h1, "R5 irq ch0");
        // R1 hold without ticks, R5 held
        repeat (3) @(negedge clk);
        chk(0, 5'h04, 32'hFFFF_FFF5, "R1 hold");
        chk(1, 5'h00, 32'h1, "R5 irq held");
        // R2 count writes ignored
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h5);
        chk(0, 5'h04, 32'hFFFF_FFF5, "R2 low unchanged");
        chk(0, 5'h08, 32'h0, "R2 high unchanged");
        // R8 unmapped / unaligned
        wr(5'h1C, 32'hFFFF_FFFF);
        wr(5'h01, 32'hFFFF_FFFF);
        chk(0, 5'h1C, 32'h0, "R8 unmapped read");
        chk(0, 5'h0D, 32'h0, "R8 unaligned read");
        chk(0, 5'h00, 32'h1, "R8 status untouched");
        chk(0, 5'h0C, 32'hFFFF_FFF5, "R8 cmp0 untouched");
        // R6 selective clear
        wr(5'h00, 32'h2);
        chk(0, 5'h00, 32'h1, "R6 zero bits keep");
        wr(5'h00, 32'h1);
        chk(0, 5'h00, 32'h0, "R6 cleared");
        chk(1, 5'h00, 32'h0, "R6 irq dropped");
        // R1 carry into high word
        ticks(11);
        chk(0, 5'h04, 32'h0, "R1 low wrapped");
        chk(0, 5'h08, 32'h1, "R1 carry");
        chk(0, 5'h00, 32'h0, "R4 no fire at wrap");
        // R4 upper bits ignored
        ticks(3);
        chk(0, 5'h00, 32'h2, "R4 ch1 fires with high=1");
        chk(1, 5'h00, 32'h2, "R5 irq ch1");
        // R7 set wins over coincident clear
        ticks(12);
        @(negedge clk);
        bus_addr = 5'h00; bus_we = 1'b1; bus_wdata = 32'h6; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        chk(0, 5'h00, 32'h4, "R7 set wins ch2, ch1 cleared");
        chk(0, 5'h04, 32'h10, "R1 low at 0x10");
        // R4 compare written to current value does not fire
        wr(5'h18, 32'h10);
        repeat (2) @(negedge clk);
        chk(0, 5'h00, 32'h4, "R4 no fire on compare write");
        ticks(1);
        chk(0, 5'h00, 32'h4, "R4 no fire past value");
        // R10 simultaneous fire
        wr(5'h0C, 32'h20);
        wr(5'h18, 32'h20);
        ticks(15);
        chk(0, 5'h00, 32'hD, "R10 two channels together");
        chk(1, 5'h00, 32'hD, "R10 irq lines");
        wr(5'h00, 32'hF);
        chk(1, 5'h00, 32'h0, "R6 clear all");
        done = 1'b1;
        finish_run();
    end

endmodule